// File: doc/BRIEF.md
# Configurable-Trigger Single Interrupt Controller

This block watches a single external interrupt pad. Software picks one of four trigger modes: low level, high level, rising edge or falling edge. When the selected event is seen, the block latches a pending flag. It then drives one interrupt request line to a parent interrupt controller. That line is qualified by a mask bit held in an enable register.

The pad is first brought into the clock domain through a chain of synchronising flops. Edges are found by comparing the synchronised value with its value one cycle earlier. A level mode keeps setting the pending flag on every cycle that the level stays active. An edge mode sets the flag once per transition.

Software works through a plain synchronous register port. It has an address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. Software clears the pending flag by writing one to it. At start-up, software is expected to mask the line and clear the pending flag before it unmasks.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, the control, enable and pending registers all read 0 and the interrupt output is low. This gives low-level mode with the line masked.
- R2: The control register at byte offset 0x0 keeps every written bit and reads back in full. Bits [1:0] pick the trigger: 0 low level, 1 falling edge, 2 high level, 3 rising edge.
- R3: The enable register is at offset 0x4. Bit 0 is the mask bit, and a 1 unmasks. All other bits read 0 whatever was written.
- R4: In rising-edge mode, a low-to-high transition of the synchronised pad sets pending. A falling transition has no effect, and a pad that stays high does not set it again after a clear.
- R5: In falling-edge mode, a high-to-low transition sets pending. A rising transition has no effect, and a pad that stays low does not set it again after a clear.
- R6: In high-level mode, pending is set on every cycle the synchronised pad is high. A clear written while the pad is high leaves pending at 1.
- R7: In low-level mode, pending is set on every cycle the synchronised pad is low.
- R8: The pending register is at offset 0x8. Writing 1 to bit 0 clears the flag, writing 0 leaves it unchanged, and bits above bit 0 read 0.
- R9: In an edge mode, when an edge and a clear land in the same cycle, the edge wins and pending stays 1.
- R10: Pending is recorded even while the line is masked. The interrupt output is a registered copy of pending AND enable, one cycle behind them.
- R11: The pad reaches the trigger logic through a chain of SYNC_STAGES flops, 2 by default. A pad event sets pending SYNC_STAGES+1 clock edges after the pad changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pad | input | 1 | Asynchronous interrupt pad |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the following cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The bench goes after the cases where the mode decides whether a clear sticks.

- A clear written while a high level persists must leave pending at 1. A design that let the clear win would lose an active level.
- A clear after an edge, while the pad holds steady, must leave pending at 0. A design that treated edge modes as levels would re-raise the interrupt for ever.
- A rising edge timed to meet a clear in the same cycle must survive. Letting the clear win would silently drop that event.

The bench also checks three things at the ports:

- Pending is captured while the line is masked.
- The output follows the mask one cycle later.
- The upper bits of the enable and pending registers read 0, while the control register keeps all of its bits.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LEVEL_LO  = 2'd0,
      TRIG_EDGE_FALL = 2'd1,
      TRIG_LEVEL_HI  = 2'd2,
      TRIG_EDGE_RISE = 2'd3
   } trig_mode_e;

   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_EN   = 4;
   localparam int unsigned OFS_PEND = 8;

endpackage

// File: rtl/irq_pad_sync.sv
module irq_pad_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pad_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
   import trig_irq_pkg::*;
(
   input  trig_mode_e mode,
   input  logic       cur,
   input  logic       prev,
   output logic       hit
);

   always_comb begin
      unique case (mode)
         TRIG_LEVEL_LO:  hit = ~cur;
         TRIG_EDGE_FALL: hit = prev & ~cur;
         TRIG_LEVEL_HI:  hit = cur;
         TRIG_EDGE_RISE: hit = cur & ~prev;
         default:        hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
   import trig_irq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        PAD_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_pad,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
   localparam int unsigned       PAD_W  = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_data
      $error("trig_irq_ctrl: DATA_W must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("trig_irq_ctrl: ADDR_W must be at least 4");
   end

   logic              pad_s;
   logic              pad_prev;
   logic              hit;
   logic [DATA_W-1:0] ctrl_q;
   logic              en_q;
   logic              pend_q;
   logic              pend_d;
   logic              irq_q;
   logic              sel_ctrl, sel_en, sel_pend;
   logic              clr_req;
   trig_mode_e        mode;

   irq_pad_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PAD_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nmi_pad),
      .q     (pad_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pad_prev <= PAD_IDLE;
      else        pad_prev <= pad_s;
   end

   assign mode = trig_mode_e'(ctrl_q[1:0]);

   irq_trig_detect u_det (
      .mode (mode),
      .cur  (pad_s),
      .prev (pad_prev),
      .hit  (hit)
   );

   assign sel_ctrl = (bus_addr == A_CTRL);
   assign sel_en   = (bus_addr == A_EN);
   assign sel_pend = (bus_addr == A_PEND);
   assign clr_req  = bus_wr & sel_pend & bus_wdata[0];

   // A detected event takes priority over a clear in the same cycle.
   always_comb begin
      if (hit)          pend_d = 1'b1;
      else if (clr_req) pend_d = 1'b0;
      else              pend_d = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
         if (bus_wr && sel_en)   en_q   <= bus_wdata[0];
         pend_q <= pend_d;
         irq_q  <= pend_q & en_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         if (sel_ctrl)      bus_rdata <= ctrl_q;
         else if (sel_en)   bus_rdata <= {{PAD_W{1'b0}}, en_q};
         else if (sel_pend) bus_rdata <= {{PAD_W{1'b0}}, pend_q};
         else               bus_rdata <= '0;
      end
   end

   assign irq_out = irq_q;

endmodule

module trig_irq_ctrl_chk
   import trig_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              wr_bit0,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_out,
   input logic              pend_q,
   input logic              en_q,
   input logic              hit,
   input logic              mode_edge
);

   logic clr_w, en_rd;
   assign clr_w = bus_wr && (bus_addr == ADDR_W'(OFS_PEND)) && wr_bit0;
   assign en_rd = bus_rd && (bus_addr == ADDR_W'(OFS_EN));

   p_en_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_rd |=> (bus_rdata[DATA_W-1:1] == '0));

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_w) |=> pend_q);

   p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_edge && hit) |=> pend_q);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !hit) |=> !pend_q);

   p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge && hit && clr_w) |=> pend_q);

   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(en_q));

   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(pend_q));

endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .wr_bit0   (bus_wdata[0]),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .pend_q    (pend_q),
   .en_q      (en_q),
   .hit       (hit),
   .mode_edge (ctrl_q[0])
);

// File: tb/sim_trig_irq_ctrl.sv
`timescale 1ns/1ps
module sim_trig_irq_ctrl;

   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_pad = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } sb_item_t;

   sb_item_t sb[$];
   logic rd_seen = 1'b0;

   always #4 clk = ~clk;

   trig_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_pad   (nmi_pad),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   // Monitor: read data lands one cycle after the strobe.
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (sb.size() == 0) begin
            failures++;
            $display("FAIL scoreboard: read data %h with no expected item", bus_rdata);
         end else begin
            sb_item_t it;
            it = sb.pop_front();
            if (bus_rdata !== it.exp) begin
               failures++;
               $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic reg_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      sb_item_t it;
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      it.exp   = e;
      it.tag   = tag;
      sb.push_back(it);
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      checks++;
      if (irq_out !== e) begin
         failures++;
         $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, e);
      end
   endtask

   task automatic set_pad(input logic v);
      @(negedge clk);
      nmi_pad = v;
      tick(4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      reg_rd(4'h0, 32'h0, "R1 ctrl reset");
      reg_rd(4'h4, 32'h0, "R1 enable reset");
      reg_rd(4'h8, 32'h0, "R1 pending reset");

      // start-up: mask and clear
      reg_wr(4'h4, 32'h0);
      reg_wr(4'h8, 32'h1);

      // R2 full control storage, rising-edge mode
      reg_wr(4'h0, 32'hABCD_0003);
      reg_rd(4'h0, 32'hABCD_0003, "R2 ctrl readback");

      // R4 rising edge
      set_pad(1'b0);
      reg_rd(4'h8, 32'h0, "R4 falling ignored in rise mode");
      set_pad(1'b1);
      reg_rd(4'h8, 32'h1, "R4 rise sets pending");
      chk_irq(1'b0, "R10 masked while pending");
      reg_wr(4'h4, 32'hFFFF_FFFF);
      reg_rd(4'h4, 32'h1, "R3 enable upper bits zero");
      chk_irq(1'b1, "R10 irq after unmask");
      reg_wr(4'h8, 32'hFFFF_FFFE);
      reg_rd(4'h8, 32'h1, "R8 write zero keeps pending");
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h0, "R4 held high no retrigger, R8 clear");
      chk_irq(1'b0, "R10 irq drops after clear");
      reg_wr(4'h4, 32'h0);

      // R5 falling edge
      reg_wr(4'h0, 32'hABCD_0001);
      set_pad(1'b0);
      reg_rd(4'h8, 32'h1, "R5 fall sets pending");
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h0, "R5 held low no retrigger");
      set_pad(1'b1);
      reg_rd(4'h8, 32'h0, "R5 rise ignored in fall mode");

      // R6 high level
      reg_wr(4'h0, 32'h2);
      reg_rd(4'h8, 32'h1, "R6 high level sets pending");
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h1, "R6 clear overridden while high");
      set_pad(1'b0);
      reg_rd(4'h8, 32'h1, "R6 pending sticky after level ends");
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h0, "R6 clear after level ends");

      // R7 low level
      reg_wr(4'h0, 32'h0);
      reg_rd(4'h8, 32'h1, "R7 low level sets pending");
      set_pad(1'b1);
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h0, "R7 clear once pad high");

      // R9 edge meets clear in the same cycle; R11 timing
      reg_wr(4'h0, 32'h3);
      set_pad(1'b0);
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h0, "R9 precondition clear");
      @(negedge clk);
      nmi_pad = 1'b1;
      @(negedge clk);
      reg_wr(4'h8, 32'h1);
      reg_rd(4'h8, 32'h1, "R9 edge wins over clear, R11 third edge");

      // R10 output follows mask
      reg_wr(4'h4, 32'h1);
      tick(1);
      chk_irq(1'b1, "R10 irq with pending and enable");
      reg_wr(4'h4, 32'h0);
      tick(1);
      chk_irq(1'b0, "R10 irq masked again");

      tick(3);
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule